// File: doc/BRIEF.md
# Badge Identifier Authorization Controller

This block decides whether a presented badge identifier may open a door. A host processor places an identifier on the `badge_id` bus and raises `request`. The block stores the identifier and compares it with a small table of allowed identifiers. The table is fixed when the design is built. On a match, the block drives `auth` high for a counted hold window. `busy` is high for the whole time the block is occupied, so the host knows when it may present the next identifier.

The controller has three named states:
- **ST_WAIT** (idle, both outputs low).
- **ST_CHECK** (table scan, `busy` high).
- **ST_GRANT** (hold window, `busy` and `auth` high).

Its transitions are:
- **t_accept**: ST_WAIT to ST_CHECK on a sampled `request`.
- **t_hit**: ST_CHECK to ST_GRANT when the table entry under the scan pointer equals the stored identifier.
- **t_miss**: ST_CHECK to ST_WAIT after the last entry fails.
- **t_expire**: ST_GRANT to ST_WAIT when the seconds count reaches `HOLD_SEC`.
- **t_reset**: any state to ST_WAIT.

Top module: `badge_auth_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to ST_WAIT, and after that edge `busy` = 0 and `auth` = 0.
- R2: In ST_WAIT with `request` low, the block stays idle with `busy` = 0 and `auth` = 0.
- R3: When `request` is high at an edge in ST_WAIT, the block stores `badge_id` and enters ST_CHECK, so `busy` = 1 and `auth` = 0 after that edge.
- R4: The table has `TABLE_N` = 8 entries. Entry k holds (k+1)*0x111 truncated to `ID_W` bits, so the entries are 0x111 through 0x888. The scan starts at entry 0 and covers one entry per clock. A match at entry k spends k+1 cycles in ST_CHECK and then enters ST_GRANT.
- R5: If no entry matches, the block returns to ST_WAIT after exactly `TABLE_N` cycles in ST_CHECK, and `auth` is never asserted.
- R6: ST_GRANT holds `busy` = 1 and `auth` = 1 for exactly `HOLD_SEC*CLK_HZ` cycles. The block then returns to ST_WAIT. The seconds count restarts from zero on every entry to ST_GRANT.
- R7: Changes on `badge_id` after the accepting edge do not affect the result of the scan in progress.
- R8: `request` is ignored while `busy` is 1. Raising it during ST_CHECK or ST_GRANT neither lengthens nor alters the current outcome.
- R9: `auth` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| request | input | 1 | Host asks for a check of `badge_id` |
| badge_id | input | ID_W | Identifier to be checked |
| busy | output | 1 | High in ST_CHECK and ST_GRANT |
| auth | output | 1 | High in ST_GRANT |

## Verification
The bench builds the block with `CLK_HZ` = 10 and `HOLD_SEC` = 4, so the grant window shrinks to 40 cycles. Every hold window can then be counted cycle by cycle, and its exact length is checked. `ID_W` stays at its default of 16. With that width, the first and last table entries, identifiers beside the table values, and the all-ones identifier can all be driven, which covers both the early-match path and the full-scan miss path.

// File: rtl/badge_auth_pkg.sv
package badge_auth_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_CHECK = 2'd1,
        ST_GRANT = 2'd2
    } auth_state_e;
endpackage

// File: rtl/badge_id_table.sv
module badge_id_table #(
    parameter int ID_W    = 16,
    parameter int TABLE_N = 8,
    localparam int IDX_W  = $clog2(TABLE_N)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [ID_W-1:0]  entry
);
    logic [ID_W-1:0] rom [TABLE_N];

    for (genvar g = 0; g < TABLE_N; g++) begin : g_rom
        localparam int VAL = (g + 1) * 32'h111;
        assign rom[g] = ID_W'(VAL);
    end

    assign entry = rom[idx];
endmodule

// File: rtl/badge_hold_timer.sv
module badge_hold_timer #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int HOLD_SEC = 4,
    localparam int TICK_W  = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1,
    localparam int SEC_W   = $clog2(HOLD_SEC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CLK_HZ - 1);
    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(HOLD_SEC - 1);

    logic [TICK_W-1:0] tick_q;
    logic [SEC_W-1:0]  sec_q;
    logic              sec_edge;

    assign sec_edge = (tick_q == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_q <= '0;
            sec_q  <= '0;
        end else if (sec_edge) begin
            tick_q <= '0;
            sec_q  <= sec_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign expired = run && sec_edge && (sec_q == SEC_LAST);

    // R6: the seconds count never passes the hold length while running
    p_sec_bound_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (sec_q < SEC_W'(HOLD_SEC)));

    // R6: each new run starts from a cleared count
    p_run_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (tick_q == '0 && sec_q == '0));
endmodule

// File: rtl/badge_auth_ctrl.sv
module badge_auth_ctrl
    import badge_auth_pkg::*;
#(
    parameter int ID_W     = 16,
    parameter int TABLE_N  = 8,
    parameter int CLK_HZ   = 50_000_000,
    parameter int HOLD_SEC = 4,
    localparam int IDX_W   = $clog2(TABLE_N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            request,
    input  logic [ID_W-1:0] badge_id,
    output logic            busy,
    output logic            auth
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TABLE_N - 1);

    auth_state_e       state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ID_W-1:0]   entry;
    logic              hit;
    logic              expired;

    badge_id_table #(.ID_W(ID_W), .TABLE_N(TABLE_N)) u_table (
        .idx   (idx_q),
        .entry (entry)
    );

    badge_hold_timer #(.CLK_HZ(CLK_HZ), .HOLD_SEC(HOLD_SEC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == ST_GRANT),
        .expired (expired)
    );

    assign hit = (entry == id_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    // captured identifier and scan pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= '0;
            idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    idx_q <= '0;
                    if (request) id_q <= badge_id;
                end
                ST_CHECK: if (!hit && idx_q != IDX_LAST) idx_q <= idx_q + 1'b1;
                default:  idx_q <= idx_q;
            endcase
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (request) state_d = ST_CHECK;                 // t_accept
            ST_CHECK: begin
                if (hit)                   state_d = ST_GRANT;         // t_hit
                else if (idx_q == IDX_LAST) state_d = ST_WAIT;         // t_miss
            end
            ST_GRANT: if (expired) state_d = ST_WAIT;                  // t_expire
            default:  state_d = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        auth = 1'b0;
        unique case (state_q)
            ST_WAIT:  ;
            ST_CHECK: busy = 1'b1;
            ST_GRANT: begin busy = 1'b1; auth = 1'b1; end
            default:  ;
        endcase
    end

    // R3: a request seen while idle starts a scan
    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && request) |=> (state_q == ST_CHECK && idx_q == '0));

    // R4: a grant is only entered from a scan
    p_grant_src_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(auth) |-> ($past(state_q) == ST_CHECK));

    // R5: a failed last entry ends the scan in idle
    p_miss_end_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !hit && idx_q == IDX_LAST) |=> (state_q == ST_WAIT));

    // R7: the stored identifier holds for the whole busy period
    p_id_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_WAIT && $past(state_q) != ST_WAIT) |-> $stable(id_q));

    // R8: a request while busy never restarts the scan
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GRANT && request && !expired) |=> (state_q == ST_GRANT));

    // R9: auth implies busy
    p_auth_busy_r9: assert property (@(posedge clk) disable iff (rst)
        auth |-> busy);
endmodule

// File: tb/sim_badge_auth_ctrl.sv
module sim_badge_auth_ctrl;
    localparam int CLK_HZ   = 10;
    localparam int HOLD_SEC = 4;
    localparam int HOLD     = CLK_HZ * HOLD_SEC;
    localparam int NVEC     = 7;
    // {id[15:0], hit[7:0], entry index[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0111, 8'd1, 8'd0},
        {16'h0888, 8'd1, 8'd7},
        {16'h0444, 8'd1, 8'd3},
        {16'h0000, 8'd0, 8'd0},
        {16'h0889, 8'd0, 8'd0},
        {16'hFFFF, 8'd0, 8'd0},
        {16'h0555, 8'd1, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        request = 1'b0;
    logic [15:0] badge_id = '0;
    logic        busy, auth;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    badge_auth_ctrl #(.ID_W(16), .TABLE_N(8), .CLK_HZ(CLK_HZ), .HOLD_SEC(HOLD_SEC)) u0 (
        .clk(clk), .rst(rst), .request(request), .badge_id(badge_id),
        .busy(busy), .auth(auth)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Accept an id, scramble the bus, then count busy and auth cycles.
    // During the busy period, req_noise drives request high with noise_id.
    task automatic run_req(input logic [15:0] id, input bit exp_hit, input int k,
                           input bit req_noise, input logic [15:0] noise_id);
        int nb, na, cap;
        @(negedge clk);
        request  = 1'b1;
        badge_id = id;
        @(negedge clk);
        request  = req_noise;
        badge_id = req_noise ? noise_id : ~id;   // R7: bus changes after capture
        chk(busy == 1'b1 && auth == 1'b0, "R3", {busy, auth}, 2);
        nb = 1; na = 0; cap = 0;
        while (busy && cap < 1000) begin
            @(negedge clk);
            if (nb == 5) request = 1'b0;
            if (busy) nb++;
            if (auth) na++;
            if (auth && !busy) chk(1'b0, "R9", 1, 0);
            cap++;
        end
        request = 1'b0;
        if (exp_hit) begin
            chk(nb == k + 1 + HOLD, "R4", nb, k + 1 + HOLD);
            chk(na == HOLD, "R6", na, HOLD);
        end else begin
            chk(nb == 8, "R5", nb, 8);
            chk(na == 0, "R5", na, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && auth == 1'b0, "R1", {busy, auth}, 0);
        // R2: idle with request low
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && auth == 1'b0, "R2", {busy, auth}, 0);

        // vector table: R4, R5, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            run_req(VEC[i][31:16], VEC[i][8], int'(VEC[i][7:0]), 1'b0, 16'h0);
            @(negedge clk);
            chk(busy == 1'b0, "R2", busy, 0);
        end

        // R8: request with a valid id during a miss scan
        run_req(16'h0000, 1'b0, 0, 1'b1, 16'h0111);
        @(negedge clk);
        chk(busy == 1'b0 && auth == 1'b0, "R8", {busy, auth}, 0);

        // R8: request during a grant keeps the window length
        run_req(16'h0222, 1'b1, 1, 1'b1, 16'h0333);

        // R1: reset in the middle of a grant
        @(negedge clk);
        request = 1'b1; badge_id = 16'h0111;
        @(negedge clk);
        request = 1'b0;
        repeat (10) @(negedge clk);
        chk(auth == 1'b1, "R6", auth, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && auth == 1'b0, "R1", {busy, auth}, 0);
        rst = 1'b0;

        // R6: fresh grant after reset counts from zero
        run_req(16'h0111, 1'b1, 0, 1'b0, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule